// File: doc/BRIEF.md
# Private Interrupt Pending-Set Logic

This block sits between a core's private interrupt sources and its pending-state storage. It watches a bank of peripheral input lines, keeps the most recent level of each one, and sends a one-cycle set strobe when an edge-configured line rises. It also receives software-generated interrupt requests, one per cycle. Each request carries a target interrupt number, a requested group and a non-secure flag. The block decides whether to accept the request from the target's configured group, its group modifier, a per-interrupt access level and a security-disable input.

Accepted requests set the pending bit of their target. Every request, accepted or not, produces a one-cycle outcome pulse. The set strobes for both sources share one vector. Software interrupts occupy the low indices and the peripheral lines occupy the indices above them, so one downstream pending register can absorb both sources in the same cycle. Priority arbitration and register access are handled elsewhere. The configuration inputs come from a neighbouring register bank.

Top module: `pirq_pend_set`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `pend_set`, `line_level`, `req_accept` and `req_reject` are all zero.
- R2: `line_level` holds the line inputs seen at the previous clock edge. A register bit is only written when its input differs from the stored value.
- R3: When an edge-configured line (`line_edge` bit 1) goes from 0 to 1, bit `NUM_SGI+i` of `pend_set` pulses for exactly one cycle, in the same cycle in which `line_level[i]` first reads 1. A line that stays high or falls produces no pulse.
- R4: A level-configured line (`line_edge` bit 0) never produces a `pend_set` pulse.
- R5: The configured group of software interrupt n is resolved as follows. `cfg_grp[n]`=1 gives non-secure group 1. `cfg_grp[n]`=0 with `cfg_mod[n]`=1 gives secure group 1. Both bits 0 gives group 0. Requested group codes on `req_grp` are 2'b00 for group 0, 2'b01 for secure group 1 and 2'b10 for non-secure group 1. Code 2'b11 is always rejected.
- R6: A request for secure group 1 whose target is configured as group 0 is treated as a group 0 request.
- R7: After the R6 adjustment, a request whose group differs from the target's configured group is rejected.
- R8: With `sec_off`=0, a non-secure request for interrupt n reads the access level at `sgi_nsacc[2n+1:2n]`. The request needs a level of at least 1 if the target is group 0 and at least 2 if the target is secure group 1; otherwise it is rejected. A non-secure group 1 target needs no particular level.
- R9: With `sec_off`=1, `cfg_mod` is treated as 0 and the access levels are not checked.
- R10: Each request with `req_valid` high yields, one cycle later, exactly one of `req_accept` and `req_reject`. An acceptance also sets only bit `req_id` among `pend_set[NUM_SGI-1:0]`. Cycles with no request yield neither pulse and no low-half set bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | NUM_LINES | Peripheral interrupt input levels |
| line_edge | input | NUM_LINES | 1 = edge-triggered line, 0 = level-triggered |
| cfg_grp | input | NUM_SGI | Group bit per software interrupt |
| cfg_mod | input | NUM_SGI | Group-modifier bit per software interrupt |
| sgi_nsacc | input | 2*NUM_SGI | Two-bit non-secure access level per software interrupt |
| sec_off | input | 1 | 1 = security disabled |
| req_valid | input | 1 | Software interrupt request present |
| req_id | input | ID_W | Target software interrupt number |
| req_grp | input | 2 | Requested group code |
| req_ns | input | 1 | Request comes from the non-secure side |
| pend_set | output | NUM_SGI+NUM_LINES | One-cycle pending-bit set strobes |
| line_level | output | NUM_LINES | Latched line levels |
| req_accept | output | 1 | Pulse: the previous cycle's request was accepted |
| req_reject | output | 1 | Pulse: the previous cycle's request was rejected |

## Verification
Within a single cycle, an edge-configured line can rise while a software request is also accepted. The two sources then write disjoint halves of `pend_set` in the same strobe. The bench causes this by raising a line and presenting an acceptable request on the same clock edge. It expects the set vector to carry both the software bit and the line bit, each at its own index, together with an acceptance pulse. It then drops the request while holding the line high and checks that no strobe appears in either half.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

  typedef enum logic [1:0] {
    GRP_G0   = 2'b00,
    GRP_G1S  = 2'b01,
    GRP_G1NS = 2'b10,
    GRP_RSVD = 2'b11
  } irq_grp_e;

  localparam logic [1:0] ACC_MIN_G0  = 2'd1;
  localparam logic [1:0] ACC_MIN_G1S = 2'd2;

endpackage

// File: rtl/pirq_line_track.sv
module pirq_line_track #(
  parameter int NUM_LINES = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] line_in,
  input  logic [NUM_LINES-1:0] line_edge,
  output logic [NUM_LINES-1:0] level_o,
  output logic [NUM_LINES-1:0] set_o
);

  logic [NUM_LINES-1:0] level_q;
  logic [NUM_LINES-1:0] set_q;
  logic [NUM_LINES-1:0] set_d;
  logic [NUM_LINES-1:0] lvl_en;

  // Per-line change detect: the enable keeps unchanged levels untouched.
  always_comb begin
    lvl_en = line_in ^ level_q;
    set_d  = lvl_en & line_in & line_edge;
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        level_q[i] <= 1'b0;
      end else if (lvl_en[i]) begin
        level_q[i] <= line_in[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_q <= '0;
    end else begin
      set_q <= set_d;
    end
  end

  assign level_o = level_q;
  assign set_o   = set_q;

  // R3: a strobe only accompanies a line that now reads high.
  p_set_implies_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (set_q & ~level_q) == '0);

  // R3: no strobe twice in a row for the same line.
  p_no_repeat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (set_q & $past(set_q)) == '0);

  // R4: level-configured lines never strobe.
  p_level_cfg_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_q & ~$past(line_edge)) == '0);

endmodule

// File: rtl/pirq_grp_resolve.sv
module pirq_grp_resolve
  import pirq_pkg::*;
#(
  parameter int NUM_SGI = 16,
  localparam int ID_W = $clog2(NUM_SGI)
) (
  input  logic [NUM_SGI-1:0] cfg_grp,
  input  logic [NUM_SGI-1:0] cfg_mod,
  input  logic               sec_off,
  input  logic [ID_W-1:0]    sel_id,
  output irq_grp_e           grp_o
);

  irq_grp_e grp_tab [NUM_SGI];

  for (genvar n = 0; n < NUM_SGI; n++) begin : g_grp
    always_comb begin
      if (cfg_grp[n]) begin
        grp_tab[n] = GRP_G1NS;
      end else if (cfg_mod[n] && !sec_off) begin
        grp_tab[n] = GRP_G1S;
      end else begin
        grp_tab[n] = GRP_G0;
      end
    end
  end

  assign grp_o = grp_tab[sel_id];

  // R9: with security disabled, secure group 1 never resolves.
  always_comb begin
    if (sec_off) begin
      a_no_g1s_secoff_r9: assert (grp_o != GRP_G1S);
    end
  end

endmodule

// File: rtl/pirq_sgi_gate.sv
module pirq_sgi_gate
  import pirq_pkg::*;
#(
  parameter int NUM_SGI = 16,
  localparam int ID_W = $clog2(NUM_SGI)
) (
  input  irq_grp_e             cfg_grp,
  input  logic [1:0]           req_grp,
  input  logic                 req_ns,
  input  logic                 sec_off,
  input  logic [ID_W-1:0]      req_id,
  input  logic [2*NUM_SGI-1:0] sgi_nsacc,
  output logic                 ok_o
);

  irq_grp_e   eff_grp;
  logic [1:0] acc_lvl;
  logic       grp_match;
  logic       acc_ok;

  always_comb begin
    eff_grp = irq_grp_e'(req_grp);
    if (eff_grp == GRP_G1S && cfg_grp == GRP_G0) begin
      eff_grp = GRP_G0;
    end
    grp_match = (eff_grp == cfg_grp) && (eff_grp != GRP_RSVD);

    acc_lvl = sgi_nsacc[2*req_id +: 2];
    acc_ok  = 1'b1;
    if (req_ns && !sec_off) begin
      case (cfg_grp)
        GRP_G0:  acc_ok = (acc_lvl >= ACC_MIN_G0);
        GRP_G1S: acc_ok = (acc_lvl >= ACC_MIN_G1S);
        default: acc_ok = 1'b1;
      endcase
    end
    ok_o = grp_match && acc_ok;
  end

endmodule

// File: rtl/pirq_pend_set.sv
module pirq_pend_set
  import pirq_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int NUM_SGI   = 16,
  localparam int ID_W     = $clog2(NUM_SGI),
  localparam int PEND_W   = NUM_SGI + NUM_LINES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] line_in,
  input  logic [NUM_LINES-1:0] line_edge,
  input  logic [NUM_SGI-1:0]   cfg_grp,
  input  logic [NUM_SGI-1:0]   cfg_mod,
  input  logic [2*NUM_SGI-1:0] sgi_nsacc,
  input  logic                 sec_off,
  input  logic                 req_valid,
  input  logic [ID_W-1:0]      req_id,
  input  logic [1:0]           req_grp,
  input  logic                 req_ns,
  output logic [PEND_W-1:0]    pend_set,
  output logic [NUM_LINES-1:0] line_level,
  output logic                 req_accept,
  output logic                 req_reject
);

  localparam logic [NUM_SGI-1:0] SGI_ONE = NUM_SGI'(1);

  irq_grp_e             tgt_grp;
  logic                 gate_ok;
  logic [NUM_LINES-1:0] line_set;
  logic [NUM_SGI-1:0]   sgi_set_d;
  logic [NUM_SGI-1:0]   sgi_set_q;
  logic                 acc_d;
  logic                 rej_d;
  logic                 acc_q;
  logic                 rej_q;

  pirq_line_track #(.NUM_LINES(NUM_LINES)) u_lines (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_in   (line_in),
    .line_edge (line_edge),
    .level_o   (line_level),
    .set_o     (line_set)
  );

  pirq_grp_resolve #(.NUM_SGI(NUM_SGI)) u_grp (
    .cfg_grp (cfg_grp),
    .cfg_mod (cfg_mod),
    .sec_off (sec_off),
    .sel_id  (req_id),
    .grp_o   (tgt_grp)
  );

  pirq_sgi_gate #(.NUM_SGI(NUM_SGI)) u_gate (
    .cfg_grp   (tgt_grp),
    .req_grp   (req_grp),
    .req_ns    (req_ns),
    .sec_off   (sec_off),
    .req_id    (req_id),
    .sgi_nsacc (sgi_nsacc),
    .ok_o      (gate_ok)
  );

  always_comb begin
    acc_d     = req_valid && gate_ok;
    rej_d     = req_valid && !gate_ok;
    sgi_set_d = acc_d ? (SGI_ONE << req_id) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= 1'b0;
      rej_q     <= 1'b0;
      sgi_set_q <= '0;
    end else begin
      acc_q     <= acc_d;
      rej_q     <= rej_d;
      sgi_set_q <= sgi_set_d;
    end
  end

  assign pend_set   = {line_set, sgi_set_q};
  assign req_accept = acc_q;
  assign req_reject = rej_q;

  // R10: one outcome per request, never both.
  p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_accept && req_reject));

  // R10: an outcome pulse only follows a presented request.
  p_outcome_needs_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_accept || req_reject) |-> $past(req_valid));

  // R10: acceptance sets exactly one low-half bit.
  p_accept_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |-> ($countones(pend_set[NUM_SGI-1:0]) == 1));

  // R7: a rejection sets nothing in the low half.
  p_reject_no_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_reject |-> (pend_set[NUM_SGI-1:0] == '0));

  // R10: no low-half set without acceptance.
  p_set_needs_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_accept |-> (pend_set[NUM_SGI-1:0] == '0));

endmodule

// File: tb/pirq_pend_set_tb.sv
module pirq_pend_set_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NL = 16;
  localparam int NS = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NL-1:0] line_in;
  logic [NL-1:0] line_edge;
  logic [NS-1:0] cfg_grp;
  logic [NS-1:0] cfg_mod;
  logic [2*NS-1:0] sgi_nsacc;
  logic          sec_off;
  logic          req_valid;
  logic [3:0]    req_id;
  logic [1:0]    req_grp;
  logic          req_ns;
  logic [NS+NL-1:0] pend_set;
  logic [NL-1:0] line_level;
  logic          req_accept;
  logic          req_reject;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pirq_pend_set #(.NUM_LINES(NL), .NUM_SGI(NS)) u_dut (
    .clk, .rst_n, .line_in, .line_edge, .cfg_grp, .cfg_mod, .sgi_nsacc,
    .sec_off, .req_valid, .req_id, .req_grp, .req_ns,
    .pend_set, .line_level, .req_accept, .req_reject
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Present one request for one cycle and judge its outcome.
  task automatic sgi(input string tag, input int id, input logic [1:0] g,
                     input logic ns, input logic exp_acc);
    @(negedge clk);
    req_valid = 1'b1; req_id = 4'(id); req_grp = g; req_ns = ns;
    tick();
    chk({tag, " accept"}, 32'(req_accept), 32'(exp_acc));
    chk({tag, " reject"}, 32'(req_reject), 32'(!exp_acc));
    chk({tag, " set"}, 32'(pend_set[NS-1:0]), exp_acc ? (32'd1 << id) : 32'd0);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    line_in = '1; line_edge = '1; cfg_grp = '0; cfg_mod = '0; sgi_nsacc = '0;
    sec_off = 1'b0; req_valid = 1'b1; req_id = '0; req_grp = 2'b00; req_ns = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 pend in reset", pend_set, 32'd0);
    chk("R1 level in reset", 32'(line_level), 32'd0);
    chk("R1 outcome in reset", 32'({req_accept, req_reject}), 32'd0);
    @(negedge clk);
    line_in = '0; req_valid = 1'b0;
    rst_n = 1'b1;
    tick();
    chk("R1 pend after release", pend_set, 32'd0);
    chk("R1 outcome after release", 32'({req_accept, req_reject}), 32'd0);
  endtask

  task automatic t_lines();
    @(negedge clk);
    line_edge = 16'h00FF;
    line_in = 16'h0101;
    tick();
    chk("R2 level follows", 32'(line_level), 32'h0101);
    chk("R3 R4 rise strobe", pend_set, 32'h0001_0000);
    @(negedge clk);
    tick();
    chk("R3 held high no strobe", pend_set, 32'd0);
    chk("R2 level held", 32'(line_level), 32'h0101);
    @(negedge clk);
    line_in = 16'h0000;
    tick();
    chk("R3 fall no strobe", pend_set, 32'd0);
    chk("R2 level falls", 32'(line_level), 32'h0000);
    @(negedge clk);
    line_in = 16'hFF00;
    tick();
    chk("R4 level lines quiet", pend_set, 32'd0);
    chk("R2 level upper", 32'(line_level), 32'hFF00);
    @(negedge clk);
    line_in = 16'h80FF;
    tick();
    chk("R3 multi rise", pend_set, 32'h00FF_0000);
    @(negedge clk);
    line_in = 16'h0000;
    tick();
  endtask

  task automatic t_groups();
    @(negedge clk);
    sec_off = 1'b0;
    cfg_grp = 16'h0002;       // SGI1 non-secure group 1
    cfg_mod = 16'h8004;       // SGI2 and SGI15 secure group 1, SGI0 group 0
    sgi_nsacc = '0;
    sgi("R5 g0 to g0", 0, 2'b00, 1'b0, 1'b1);
    sgi("R6 g1s to g0", 0, 2'b01, 1'b0, 1'b1);
    sgi("R7 g1ns to g0", 0, 2'b10, 1'b0, 1'b0);
    sgi("R5 g1s to g1s", 2, 2'b01, 1'b0, 1'b1);
    sgi("R7 g0 to g1s", 2, 2'b00, 1'b0, 1'b0);
    sgi("R5 g1ns to g1ns", 1, 2'b10, 1'b0, 1'b1);
    sgi("R7 g1s to g1ns", 1, 2'b01, 1'b0, 1'b0);
    sgi("R5 reserved code", 1, 2'b11, 1'b0, 1'b0);
    sgi("R10 top index", 15, 2'b01, 1'b0, 1'b1);
  endtask

  task automatic t_access();
    @(negedge clk);
    sec_off = 1'b0;
    sgi_nsacc = '0;
    sgi("R8 ns g0 level0", 0, 2'b00, 1'b1, 1'b0);
    @(negedge clk); sgi_nsacc[1:0] = 2'd1;
    sgi("R8 ns g0 level1", 0, 2'b00, 1'b1, 1'b1);
    @(negedge clk); sgi_nsacc[5:4] = 2'd1;
    sgi("R8 ns g1s level1", 2, 2'b01, 1'b1, 1'b0);
    @(negedge clk); sgi_nsacc[5:4] = 2'd2;
    sgi("R8 ns g1s level2", 2, 2'b01, 1'b1, 1'b1);
    @(negedge clk); sgi_nsacc[1:0] = 2'd0; sgi_nsacc[5:4] = 2'd3;
    sgi("R8 field isolation", 0, 2'b00, 1'b1, 1'b0);
    sgi("R8 ns g1ns level0", 1, 2'b10, 1'b1, 1'b1);
  endtask

  task automatic t_secoff();
    @(negedge clk);
    sec_off = 1'b1;
    sgi_nsacc = '0;
    sgi("R9 ns no access check", 0, 2'b00, 1'b1, 1'b1);
    sgi("R9 modifier ignored", 2, 2'b00, 1'b1, 1'b1);
    sgi("R9 g1s folds to g0", 2, 2'b01, 1'b0, 1'b1);
    sgi("R9 g1ns target kept", 1, 2'b01, 1'b0, 1'b0);
    @(negedge clk);
    sec_off = 1'b0;
  endtask

  task automatic t_idle();
    @(negedge clk);
    req_valid = 1'b0; req_id = 4'd3; req_grp = 2'b00;
    tick();
    chk("R10 idle no outcome", 32'({req_accept, req_reject}), 32'd0);
    chk("R10 idle no set", pend_set, 32'd0);
  endtask

  task automatic t_concurrent();
    @(negedge clk);
    cfg_grp = '0; cfg_mod = '0; sec_off = 1'b0;
    line_edge = 16'h0008;
    line_in = 16'h0008;
    req_valid = 1'b1; req_id = 4'd5; req_grp = 2'b00; req_ns = 1'b0;
    tick();
    chk("R3 R10 merged strobe", pend_set, 32'h0008_0020);
    chk("R10 merged accept", 32'(req_accept), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    tick();
    chk("R3 R10 merged quiet after", pend_set, 32'd0);
    @(negedge clk);
    line_in = '0;
  endtask

  initial begin
    t_reset();
    t_lines();
    t_groups();
    t_access();
    t_secoff();
    t_idle();
    t_concurrent();
    repeat (2) @(posedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog run did not finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule